// File: doc/BRIEF.md
# Flash Frame Programming Sequencer

This block turns two single-cycle requests, erase and program, into a sequence of commands for a NOR flash controller. A configuration slot is chosen by loading a start address, which comes from a separate serial command path. An erase request makes the block walk the erase blocks of that slot one at a time. It issues one block-erase command per block and never a whole-chip erase.

A program request takes one buffered configuration frame of 4096 bits and sends it as a run of write-buffer program commands. Each command carries 16 words of 16 bits and its own address. The 16 words of a burst are read from the frame buffer and streamed behind the command. After each command the block waits for a completion pulse from the flash controller before it issues the next one.

A running write address starts at the slot start address. It moves forward by one frame (256 words) after every frame that completes, so consecutive program requests fill the slot in order. While a sequence is running, the block reports busy and rejects new requests by raising a sticky error flag.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, busy, err, cmd_valid, wdata_valid and buf_rd_en are all 0.
- R2: An erase request accepted while idle produces SLOT_BLOCKS (default 4) commands with cmd_op = 2'b01 (block erase). They are issued in ascending order at addresses slot start + k*BLOCK_WORDS (BLOCK_WORDS default 65536), for k = 0 up to SLOT_BLOCKS-1, and no write data is sent.
- R3: cmd_op is never 2'b11 (whole-chip erase) or 2'b00 while cmd_valid is high. Every erase address lies inside the current slot span of SLOT_BLOCKS*BLOCK_WORDS words.
- R4: A program request accepted while idle produces 16 commands with cmd_op = 2'b10 (write-buffer program). Command j (j = 0..15) uses address frame address + 16*j.
- R5: After command j of a frame is accepted, exactly 16 wdata_valid beats follow. They carry frame buffer words 16*j to 16*j+15 in order. The buffer returns the word addressed by buf_rd_addr one cycle after buf_rd_en.
- R6: The first frame after an accepted slot load is written at the slot start address. Each completed frame moves the next frame's address up by 256 words.
- R7: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and cmd_addr and cmd_op do not change.
- R8: A new command is presented only when the block is idle, or after fc_done has ended the previous command. No command is accepted while the previous one is still outstanding.
- R9: busy is 1 from the cycle after an accepted request until the cycle after the fc_done of the final command.
- R10: An erase or program request that arrives while busy is ignored and sets err. An accepted slot load clears err.
- R11: If erase and program requests arrive in the same idle cycle, the erase runs, the program request is dropped, and err is set.
- R12: A slot load that arrives while busy is ignored and sets err. The running write address and slot address are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_load | input | 1 | Pulse: take slot_base as the new slot start |
| slot_base | input | ADDR_W | Slot start address (word address) |
| erase_req | input | 1 | Pulse: erase every block of the slot |
| prog_req | input | 1 | Pulse: program the buffered frame |
| buf_rd_en | output | 1 | Frame buffer read strobe |
| buf_rd_addr | output | log2(FRAME_BITS/DATA_W) | Word index within the frame |
| buf_rd_data | input | DATA_W | Buffer word, valid one cycle after buf_rd_en |
| cmd_valid | output | 1 | Command presented to the flash controller |
| cmd_op | output | 2 | 01 block erase, 10 write-buffer program |
| cmd_addr | output | ADDR_W | Command word address |
| cmd_ready | input | 1 | Flash controller accepts the command |
| wdata_valid | output | 1 | Write-buffer data beat |
| wdata | output | DATA_W | Write-buffer data word |
| fc_done | input | 1 | Pulse: current command finished in flash |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Sticky: a request was rejected |

## Verification
The assertions take the flash controller to be well behaved. It raises cmd_ready only while a command is presented. It gives exactly one fc_done per accepted command, and for a program command it does so only after all 16 data beats have been delivered. The frame buffer is assumed to answer with a fixed one-cycle read latency. The bench's controller model counts the beats it receives before it pulses fc_done, and varies its ready and done delays between runs. Requests are driven as single-cycle pulses between clock edges.

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int ADDR_W      = 26,
  parameter int DATA_W      = 16,
  parameter int FRAME_BITS  = 4096,
  parameter int BURST_WORDS = 16,
  parameter int BLOCK_WORDS = 65536,
  parameter int SLOT_BLOCKS = 4,
  localparam int FRAME_WORDS = FRAME_BITS / DATA_W,
  localparam int FW          = $clog2(FRAME_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_load,
  input  logic [ADDR_W-1:0] slot_base,
  input  logic              erase_req,
  input  logic              prog_req,
  output logic              buf_rd_en,
  output logic [FW-1:0]     buf_rd_addr,
  input  logic [DATA_W-1:0] buf_rd_data,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_ready,
  output logic              wdata_valid,
  output logic [DATA_W-1:0] wdata,
  input  logic              fc_done,
  output logic              busy,
  output logic              err
);
  localparam int BURSTS = FRAME_WORDS / BURST_WORDS;
  localparam int WW     = $clog2(BURST_WORDS);
  localparam int BW     = $clog2(BURSTS);
  localparam int EW     = (SLOT_BLOCKS > 1) ? $clog2(SLOT_BLOCKS) : 1;
  localparam int BLK_SH = $clog2(BLOCK_WORDS);
  localparam logic [1:0] OP_ERASE = 2'b01;
  localparam logic [1:0] OP_PROG  = 2'b10;
  localparam logic [ADDR_W-1:0] SLOT_SPAN = ADDR_W'(SLOT_BLOCKS * BLOCK_WORDS);

  typedef enum logic [2:0] {S_IDLE, S_ERASE, S_PCMD, S_PDATA, S_WAIT} st_t;
  st_t st;

  logic [ADDR_W-1:0] slot_q, frame_q;
  logic [EW-1:0]     blk_q;
  logic [BW-1:0]     burst_q;
  logic [WW-1:0]     word_q;
  logic              rd_pend_q, err_q, is_erase_q;

  wire idle       = (st == S_IDLE);
  wire last_word  = (word_q == WW'(BURST_WORDS - 1));
  wire last_burst = (burst_q == BW'(BURSTS - 1));
  wire last_blk   = (blk_q == EW'(SLOT_BLOCKS - 1));

  assign busy        = !idle;
  assign err         = err_q;
  assign cmd_valid   = (st == S_ERASE) || (st == S_PCMD);
  assign cmd_op      = (st == S_ERASE) ? OP_ERASE : (st == S_PCMD) ? OP_PROG : 2'b00;
  assign cmd_addr    = (st == S_ERASE) ? slot_q + (ADDR_W'(blk_q) << BLK_SH)
                                       : frame_q + (ADDR_W'(burst_q) << WW);
  assign buf_rd_en   = (st == S_PDATA);
  assign buf_rd_addr = {burst_q, word_q};
  assign wdata_valid = rd_pend_q;
  assign wdata       = buf_rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      slot_q     <= '0;
      frame_q    <= '0;
      blk_q      <= '0;
      burst_q    <= '0;
      word_q     <= '0;
      rd_pend_q  <= 1'b0;
      err_q      <= 1'b0;
      is_erase_q <= 1'b0;
    end else begin
      rd_pend_q <= (st == S_PDATA);
      case (st)
        S_IDLE:
          if (slot_load) begin
            slot_q  <= slot_base;
            frame_q <= slot_base;
            err_q   <= erase_req | prog_req;
          end else if (erase_req) begin
            st         <= S_ERASE;
            blk_q      <= '0;
            is_erase_q <= 1'b1;
            if (prog_req) err_q <= 1'b1;
          end else if (prog_req) begin
            st         <= S_PCMD;
            burst_q    <= '0;
            is_erase_q <= 1'b0;
          end
        S_ERASE: if (cmd_ready) st <= S_WAIT;
        S_PCMD:
          if (cmd_ready) begin
            st     <= S_PDATA;
            word_q <= '0;
          end
        S_PDATA: begin
          word_q <= word_q + 1'b1;
          if (last_word) st <= S_WAIT;
        end
        S_WAIT:
          if (fc_done) begin
            if (is_erase_q) begin
              if (last_blk) st <= S_IDLE;
              else begin
                blk_q <= blk_q + 1'b1;
                st    <= S_ERASE;
              end
            end else if (last_burst) begin
              st      <= S_IDLE;
              frame_q <= frame_q + ADDR_W'(FRAME_WORDS);
            end else begin
              burst_q <= burst_q + 1'b1;
              st      <= S_PCMD;
            end
          end
        default: st <= S_IDLE;
      endcase
      if (!idle && (erase_req || prog_req || slot_load)) err_q <= 1'b1;
    end
  end

  logic [ADDR_W-1:0] erase_off;
  assign erase_off = cmd_addr - slot_q;

  assert_op_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((cmd_op == OP_ERASE) || (cmd_op == OP_PROG)));
  assert_erase_in_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ERASE) |-> (erase_off < SLOT_SPAN));
  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_op)));
  assert_cmd_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> ($past(fc_done) || !$past(busy)));
  assert_busy_on_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (erase_req || prog_req) && !slot_load) |=> busy);
  assert_err_on_busy_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (erase_req || prog_req || slot_load)) |=> err);
  assert_data_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_valid |-> (busy && !cmd_valid));
endmodule

// File: tb/flash_prog_seq_tb_top.sv
`timescale 1ns/1ps
module flash_prog_seq_tb_top;
  localparam int AW = 26;
  logic clk = 1'b0, rst_n = 1'b0;
  logic slot_load = 1'b0, erase_req = 1'b0, prog_req = 1'b0;
  logic [AW-1:0] slot_base = '0;
  logic buf_rd_en, cmd_valid, wdata_valid, busy, err;
  logic [7:0] buf_rd_addr;
  logic [15:0] buf_rd_data = '0, wdata;
  logic [1:0] cmd_op;
  logic [AW-1:0] cmd_addr;
  logic cmd_ready = 1'b0, fc_done = 1'b0;

  int checks = 0, failures = 0;
  logic [7:0] tag = 8'h00;
  int rdy_lat = 0, done_lat = 2;
  logic log_clr = 1'b0;

  logic [AW-1:0] log_addr [0:31];
  logic [1:0]    log_op   [0:31];
  logic [15:0]   log_data [0:511];
  int ncmd = 0, ndata = 0, viol_r7 = 0, viol_r8 = 0;
  int rdy_cnt = 0, done_cnt = 0, beats_got = 0, beats_need = 0;
  logic pend = 1'b0, prev_wait = 1'b0;
  logic [AW-1:0] prev_addr = '0;

  always #4 clk = ~clk;

  flash_prog_seq dut_i (
    .clk(clk), .rst_n(rst_n), .slot_load(slot_load), .slot_base(slot_base),
    .erase_req(erase_req), .prog_req(prog_req), .buf_rd_en(buf_rd_en),
    .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_ready(cmd_ready),
    .wdata_valid(wdata_valid), .wdata(wdata), .fc_done(fc_done),
    .busy(busy), .err(err));

  always @(posedge clk) if (buf_rd_en) buf_rd_data <= {tag, buf_rd_addr};

  always @(posedge clk) begin
    cmd_ready <= 1'b0;
    fc_done   <= 1'b0;
    if (!rst_n) begin
      pend <= 1'b0;
      rdy_cnt <= 0;
      prev_wait <= 1'b0;
    end else begin
      if (log_clr) begin
        ncmd <= 0;
        ndata <= 0;
      end
      if (prev_wait && cmd_addr != prev_addr) viol_r7 <= viol_r7 + 1;
      prev_wait <= cmd_valid && !cmd_ready;
      prev_addr <= cmd_addr;
      if (cmd_valid && !cmd_ready) begin
        if (rdy_cnt >= rdy_lat) begin
          cmd_ready <= 1'b1;
          rdy_cnt <= 0;
        end else rdy_cnt <= rdy_cnt + 1;
      end
      if (cmd_valid && cmd_ready) begin
        if (pend) viol_r8 <= viol_r8 + 1;
        if (ncmd < 32) begin
          log_addr[ncmd] <= cmd_addr;
          log_op[ncmd]   <= cmd_op;
        end
        ncmd <= ncmd + 1;
        pend <= 1'b1;
        beats_got <= 0;
        beats_need <= (cmd_op == 2'b10) ? 16 : 0;
        done_cnt <= 0;
      end else if (pend) begin
        if (wdata_valid) beats_got <= beats_got + 1;
        if (beats_got == beats_need && !wdata_valid) begin
          if (done_cnt >= done_lat) begin
            fc_done <= 1'b1;
            pend <= 1'b0;
          end else done_cnt <= done_cnt + 1;
        end
      end
      if (wdata_valid) begin
        if (ndata < 512) log_data[ndata] <= wdata;
        ndata <= ndata + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(negedge clk) log_clr = 1'b1;
    @(negedge clk) log_clr = 1'b0;
  endtask

  task automatic load_slot(input logic [AW-1:0] b);
    @(negedge clk);
    slot_load = 1'b1;
    slot_base = b;
    @(negedge clk) slot_load = 1'b0;
  endtask

  task automatic pulse(input bit er, input bit pr);
    @(negedge clk);
    erase_req = er;
    prog_req = pr;
    @(negedge clk);
    erase_req = 1'b0;
    prog_req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_erase(input logic [AW-1:0] b, input string req);
    chk(ncmd == 4, req, ncmd, 4);
    chk(ndata == 0, req, ndata, 0);
    for (int k = 0; k < 4; k++) begin
      chk(log_op[k] == 2'b01, "R3 op", log_op[k], 2'b01);
      chk(log_addr[k] == b + AW'(k * 65536), req, log_addr[k], b + AW'(k * 65536));
    end
  endtask

  task automatic check_prog(input logic [AW-1:0] fa, input string req);
    chk(ncmd == 16, {req, " R4 count"}, ncmd, 16);
    chk(ndata == 256, {req, " R5 beats"}, ndata, 256);
    for (int j = 0; j < 16; j++) begin
      chk(log_op[j] == 2'b10, "R4 op", log_op[j], 2'b10);
      chk(log_addr[j] == fa + AW'(16 * j), {req, " R4 addr"}, log_addr[j], fa + AW'(16 * j));
    end
    for (int w = 0; w < 256; w++)
      chk(log_data[w] == {tag, 8'(w)}, "R5 data", log_data[w], {tag, 8'(w)});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!busy && !err && !cmd_valid && !wdata_valid && !buf_rd_en, "R1 reset",
        {busy, err, cmd_valid, wdata_valid, buf_rd_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !cmd_valid, "R1 after release", {busy, cmd_valid}, 0);
  endtask

  task automatic t_erase();
    load_slot(26'h0100000);
    clear_logs();
    pulse(1'b1, 1'b0);
    chk(busy == 1'b1, "R9 busy after erase", busy, 1);
    wait_idle();
    check_erase(26'h0100000, "R2 erase");
    chk(err == 1'b0, "R2 no err", err, 0);
  endtask

  task automatic t_prog_two();
    rdy_lat = 0; done_lat = 2; tag = 8'h3C;
    clear_logs();
    pulse(1'b0, 1'b1);
    chk(busy == 1'b1, "R9 busy after program", busy, 1);
    wait_idle();
    chk(busy == 1'b0, "R9 idle at end", busy, 0);
    check_prog(26'h0100000, "R6 first frame");
    rdy_lat = 3; done_lat = 5; tag = 8'h5A;
    clear_logs();
    pulse(1'b0, 1'b1);
    wait_idle();
    check_prog(26'h0100100, "R6 second frame");
    chk(viol_r7 == 0, "R7 hold", viol_r7, 0);
  endtask

  task automatic t_busy_req();
    rdy_lat = 1; done_lat = 1; tag = 8'hC3;
    clear_logs();
    pulse(1'b0, 1'b1);
    repeat (20) @(negedge clk);
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    wait_idle();
    check_prog(26'h0100200, "R10 ignored");
    chk(err == 1'b1, "R10 err set", err, 1);
    load_slot(26'h0200000);
    chk(err == 1'b0, "R10 err cleared", err, 0);
  endtask

  task automatic t_simul();
    clear_logs();
    pulse(1'b1, 1'b1);
    wait_idle();
    check_erase(26'h0200000, "R11 erase wins");
    chk(err == 1'b1, "R11 err", err, 1);
  endtask

  task automatic t_slot_busy();
    load_slot(26'h0200000);
    rdy_lat = 0; done_lat = 0; tag = 8'h11;
    clear_logs();
    pulse(1'b0, 1'b1);
    repeat (10) @(negedge clk);
    load_slot(26'h0300000);
    wait_idle();
    check_prog(26'h0200000, "R12 running frame");
    chk(err == 1'b1, "R12 err", err, 1);
    tag = 8'h22;
    clear_logs();
    pulse(1'b0, 1'b1);
    wait_idle();
    check_prog(26'h0200100, "R12 address kept");
    load_slot(26'h0300000);
    tag = 8'h33;
    clear_logs();
    pulse(1'b0, 1'b1);
    wait_idle();
    check_prog(26'h0300000, "R6 new slot");
    chk(viol_r8 == 0, "R8 one outstanding", viol_r8, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_erase();
    t_prog_two();
    t_busy_req();
    t_simul();
    t_slot_busy();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule